// File: doc/BRIEF.md
# Interrupt Arbiter with Illegal-Fetch Trap

This block sits beside the fetch and data-read paths of a small 8-bit controller core and makes every interrupt decision for it. Instruction bytes and data bytes pass through it on their way into the core. An instruction byte fetched from beyond the implemented program memory is replaced by 0x00, which is the software-trap opcode. A data read from unimplemented data memory returns 0xFF. Between them, these two rules send a runaway program into the trap handler. A jump past the end of program memory leads there directly. An extra return that pops a stack slot above the initial stack top reads all ones, so the program counter becomes 0xFFFF, and the next fetch from that address also leads there.

The block holds the 8-bit status register, which contains the global enable, the per-source enables and the pending flags. Timer events and edges on the external pin set the pending flags. At each instruction boundary the block chooses at most one of three sources: the external interrupt, the timer interrupt, or the software trap that the core requests when it decodes opcode 0x00. For the chosen source it raises a one-hot take signal and drives a fixed vector address. Taking a hardware interrupt clears the global enable. Taking the software trap leaves the global enable as it was, so hardware interrupts can still preempt the trap handler.

Top module: `intarb_top`

## Requirements
- R1: When fetch_valid is high and fetch_addr is at or below 0x2FF, opcode shows rom_data on the cycle after the clock edge, and illegal_fetch is 0 on that cycle.
- R2: When fetch_valid is high and fetch_addr is above 0x2FF, opcode shows 0x00 on the cycle after the clock edge, and illegal_fetch is 1 for exactly that one cycle.
- R3: dmem_rdata equals dmem_rdata_raw when dmem_addr is in 0x00..0x2F or 0xE0..0xFF. For every other address, including 0x30 and 0x31, dmem_rdata is 0xFF.
- R4: The status register psw_q has these fields: bit7 HC, bit6 C, bit5 timer pending, bit4 timer enable, bit3 external pending, bit2 BUSY, bit1 external enable, bit0 global enable. It resets to 0x00, and a psw_we cycle loads all eight bits from psw_wdata.
- R5: A timer_event cycle sets bit5. An edge on ext_pin in the direction chosen by ext_rising (1 = rising, 0 = falling) sets bit3. An edge in the opposite direction leaves bit3 unchanged.
- R6: If a pending bit's event arrives in the same cycle as a write of zero to that bit, the bit ends up set.
- R7: At insn_boundary, the external source is taken when bits 0, 1 and 3 are all set. The timer source is taken when bits 0, 4 and 5 are all set. The external source outranks the timer source. The take bits are take[0] external, take[1] timer and take[2] software, with vectors 0x00F8, 0x00F4 and 0x00F0. When nothing is taken, take is 0 and vector is 0.
- R8: A software trap (sw_trap_req at insn_boundary) is taken only when no hardware source meets its R7 condition. A pending bit whose enable or global enable is clear does not block the trap.
- R9: Taking a hardware interrupt clears bit 0 at the clock edge, even if a write to bit 0 happens in the same cycle. The pending bits are left unchanged.
- R10: Taking the software trap leaves bit 0 unchanged.
- R11: When insn_boundary is low, take is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction byte is being fetched this cycle |
| fetch_addr | input | 16 | Program-memory fetch address |
| rom_data | input | 8 | Raw byte from program memory |
| opcode | output | 8 | Registered opcode for the core |
| illegal_fetch | output | 1 | The last fetch was substituted with 0x00 |
| dmem_addr | input | 8 | Data-memory read address |
| dmem_rdata_raw | input | 8 | Raw byte from data memory |
| dmem_rdata | output | 8 | Filtered read data for the core |
| ext_pin | input | 1 | External interrupt pin |
| ext_rising | input | 1 | Edge polarity select: 1 = rising, 0 = falling |
| timer_event | input | 1 | Timer underflow or capture pulse |
| psw_we | input | 1 | Software write strobe for the status register |
| psw_wdata | input | 8 | Status register write data |
| psw_q | output | 8 | Status register contents |
| insn_boundary | input | 1 | The core can accept an interrupt this cycle |
| sw_trap_req | input | 1 | The core decoded opcode 0x00 |
| take | output | 3 | One-hot take: bit0 external, bit1 timer, bit2 software |
| vector | output | 16 | Vector address of the taken source |

## Verification
The bench drives fetches just below and just above the program-memory limit. If the limit comparison is off by one, a legal byte at 0x2FF gets trapped, or 0x300 gets through. It walks the over-pop path by reading 0x30 and 0x31 and then fetching from 0xFFFF, and it also checks the data-memory window edges at 0x2F and 0xE0. On the arbitration side, it makes a software trap and hardware sources compete. It keeps a pending bit set while its enable is clear, to show that a disabled request does not block the trap. It collides a clearing write with a new event and with a hardware take. A design with the wrong priority, a design that clears the global enable on a software trap, or a design that lets a write beat an event or a take would show the wrong take bits or the wrong status byte.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  // status register bit positions (software decodes these)
  localparam int SR_GIE  = 0;
  localparam int SR_ENX  = 1;
  localparam int SR_BUSY = 2;
  localparam int SR_XPND = 3;
  localparam int SR_ENT  = 4;
  localparam int SR_TPND = 5;
  localparam int SR_C    = 6;
  localparam int SR_HC   = 7;
  localparam int SR_W    = 8;

  // one-hot take bit positions
  localparam int TK_EXT = 0;
  localparam int TK_TMR = 1;
  localparam int TK_SW  = 2;
  localparam int TK_N   = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_SW   = 2'd3
  } src_e;
endpackage

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] ROM_LAST = 16'h02FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [DW-1:0] rom_data,
  output logic [DW-1:0] opcode,
  output logic          illegal_fetch
);
  logic          beyond;
  logic [DW-1:0] op_d, op_q;
  logic          ill_d, ill_q;

  always_comb begin
    beyond = (fetch_addr > ROM_LAST);
    op_d   = op_q;
    if (fetch_valid) op_d = beyond ? '0 : rom_data;
    ill_d  = fetch_valid & beyond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      if (fetch_valid) op_q <= op_d;
      ill_q <= ill_d;
    end
  end

  assign opcode        = op_q;
  assign illegal_fetch = ill_q;

  assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_fetch |-> (opcode == '0));

  assert_legal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_addr <= ROM_LAST) |=> (opcode == $past(rom_data) && !illegal_fetch));
endmodule

// File: rtl/dmem_guard.sv
module dmem_guard #(
  parameter int DAW = 8,
  parameter int DW  = 8,
  parameter logic [DAW-1:0] RAM_LAST = 8'h2F,
  parameter logic [DAW-1:0] REG_BASE = 8'hE0
) (
  input  logic [DAW-1:0] dmem_addr,
  input  logic [DW-1:0]  rdata_raw,
  output logic [DW-1:0]  rdata
);
  logic mapped;

  always_comb begin
    mapped = (dmem_addr <= RAM_LAST) || (dmem_addr >= REG_BASE);
    rdata  = mapped ? rdata_raw : '1;
  end
endmodule

// File: rtl/edge_det.sv
module edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rising_sel,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  always_comb begin
    if (rising_sel) evt = pin & ~prev_q;
    else            evt = ~pin & prev_q;
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import intarb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SR_W-1:0] wdata,
  input  logic            tmr_evt,
  input  logic            ext_evt,
  input  logic            hw_take,
  output logic [SR_W-1:0] sr_q
);
  logic [SR_W-1:0] sr_d;
  logic            upd;

  always_comb begin
    sr_d = we ? wdata : sr_q;
    if (hw_take) sr_d[SR_GIE]  = 1'b0;
    if (tmr_evt) sr_d[SR_TPND] = 1'b1;
    if (ext_evt) sr_d[SR_XPND] = 1'b1;
    upd = we | hw_take | tmr_evt | ext_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr_q <= '0;
    else if (upd) sr_q <= sr_d;
  end

  assert_tmr_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> sr_q[SR_TPND]);

  assert_ext_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> sr_q[SR_XPND]);

  assert_hw_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> !sr_q[SR_GIE]);

  assert_hw_keeps_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && !we) |=> (sr_q[SR_TPND] == $past(sr_q[SR_TPND]) || $past(tmr_evt)));
endmodule

// File: rtl/take_arbiter.sv
module take_arbiter
  import intarb_pkg::*;
#(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_EXT = 16'h00F8,
  parameter logic [VW-1:0] VEC_TMR = 16'h00F4,
  parameter logic [VW-1:0] VEC_SW  = 16'h00F0
) (
  input  logic            boundary,
  input  logic            sw_req,
  input  logic [SR_W-1:0] sr,
  output logic [TK_N-1:0] take,
  output logic [VW-1:0]   vector,
  output logic            hw_take
);
  logic ext_req, tmr_req;
  src_e sel;

  always_comb begin
    ext_req = sr[SR_GIE] & sr[SR_ENX] & sr[SR_XPND];
    tmr_req = sr[SR_GIE] & sr[SR_ENT] & sr[SR_TPND];
    sel = SRC_NONE;
    if (boundary) begin
      if (ext_req)      sel = SRC_EXT;
      else if (tmr_req) sel = SRC_TMR;
      else if (sw_req)  sel = SRC_SW;
    end
  end

  always_comb begin
    take   = '0;
    vector = '0;
    unique case (sel)
      SRC_EXT: begin take[TK_EXT] = 1'b1; vector = VEC_EXT; end
      SRC_TMR: begin take[TK_TMR] = 1'b1; vector = VEC_TMR; end
      SRC_SW:  begin take[TK_SW]  = 1'b1; vector = VEC_SW;  end
      default: ;
    endcase
    hw_take = (sel == SRC_EXT) || (sel == SRC_TMR);
  end
endmodule

// File: rtl/intarb_top.sv
module intarb_top
  import intarb_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int DAW = 8,
  parameter logic [AW-1:0]  ROM_LAST = 16'h02FF,
  parameter logic [DAW-1:0] RAM_LAST = 8'h2F,
  parameter logic [DAW-1:0] REG_BASE = 8'hE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic [DW-1:0]   rom_data,
  output logic [DW-1:0]   opcode,
  output logic            illegal_fetch,
  input  logic [DAW-1:0]  dmem_addr,
  input  logic [DW-1:0]   dmem_rdata_raw,
  output logic [DW-1:0]   dmem_rdata,
  input  logic            ext_pin,
  input  logic            ext_rising,
  input  logic            timer_event,
  input  logic            psw_we,
  input  logic [SR_W-1:0] psw_wdata,
  output logic [SR_W-1:0] psw_q,
  input  logic            insn_boundary,
  input  logic            sw_trap_req,
  output logic [TK_N-1:0] take,
  output logic [AW-1:0]   vector
);
  logic ext_evt;
  logic hw_take;

  fetch_guard #(.AW(AW), .DW(DW), .ROM_LAST(ROM_LAST)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .rom_data(rom_data), .opcode(opcode), .illegal_fetch(illegal_fetch));

  dmem_guard #(.DAW(DAW), .DW(DW), .RAM_LAST(RAM_LAST), .REG_BASE(REG_BASE)) u_dmem (
    .dmem_addr(dmem_addr), .rdata_raw(dmem_rdata_raw), .rdata(dmem_rdata));

  edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rising_sel(ext_rising), .evt(ext_evt));

  status_reg u_sr (
    .clk(clk), .rst_n(rst_n), .we(psw_we), .wdata(psw_wdata), .tmr_evt(timer_event),
    .ext_evt(ext_evt), .hw_take(hw_take), .sr_q(psw_q));

  take_arbiter #(.VW(AW)) u_arb (
    .boundary(insn_boundary), .sw_req(sw_trap_req), .sr(psw_q),
    .take(take), .vector(vector), .hw_take(hw_take));

  assert_take_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  assert_sw_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take[TK_SW] |-> !(psw_q[SR_GIE] && ((psw_q[SR_ENX] && psw_q[SR_XPND]) ||
                                        (psw_q[SR_ENT] && psw_q[SR_TPND]))));

  assert_sw_keeps_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take[TK_SW] && !psw_we) |=> (psw_q[SR_GIE] == $past(psw_q[SR_GIE])));

  assert_idle_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |-> (take == '0));
endmodule

// File: tb/tb_intarb_top.sv
`timescale 1ns/1ps
module tb_intarb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [15:0] fetch_addr;
  logic [7:0]  rom_data;
  logic [7:0]  opcode;
  logic        illegal_fetch;
  logic [7:0]  dmem_addr;
  logic [7:0]  dmem_rdata_raw;
  logic [7:0]  dmem_rdata;
  logic        ext_pin, ext_rising, timer_event;
  logic        psw_we;
  logic [7:0]  psw_wdata;
  logic [7:0]  psw_q;
  logic        insn_boundary, sw_trap_req;
  logic [2:0]  take;
  logic [15:0] vector;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intarb_top dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_psw(input logic [7:0] v);
    psw_we = 1'b1; psw_wdata = v;
    step();
    psw_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset psw", {8'h0, psw_q}, 16'h0000);
    chk("R1 reset illegal", {15'h0, illegal_fetch}, 16'h0);
    chk("R11 reset take", {13'h0, take}, 16'h0);
  endtask

  task automatic t_fetch();
    fetch_valid = 1'b1; fetch_addr = 16'h02FF; rom_data = 8'h5A;
    step();
    chk("R1 opcode at 0x2FF", {8'h0, opcode}, 16'h005A);
    chk("R1 no illegal at 0x2FF", {15'h0, illegal_fetch}, 16'h0);
    fetch_addr = 16'h0300; rom_data = 8'hC3;
    step();
    fetch_valid = 1'b0;
    chk("R2 opcode at 0x300", {8'h0, opcode}, 16'h0000);
    chk("R2 illegal at 0x300", {15'h0, illegal_fetch}, 16'h1);
    step();
    chk("R2 illegal one cycle", {15'h0, illegal_fetch}, 16'h0);
    fetch_valid = 1'b1; fetch_addr = 16'h0010; rom_data = 8'h00;
    step();
    chk("R2 real zero not flagged", {15'h0, illegal_fetch}, 16'h0);
    fetch_valid = 1'b0;
  endtask

  task automatic t_dmem();
    dmem_rdata_raw = 8'h12;
    dmem_addr = 8'h2F; #0.5 chk("R3 addr 0x2F passes", {8'h0, dmem_rdata}, 16'h0012);
    dmem_addr = 8'hE0; #0.5 chk("R3 addr 0xE0 passes", {8'h0, dmem_rdata}, 16'h0012);
    dmem_addr = 8'hDF; #0.5 chk("R3 addr 0xDF reads FF", {8'h0, dmem_rdata}, 16'h00FF);
  endtask

  task automatic t_overpop();
    logic [7:0] lo, hi;
    dmem_rdata_raw = 8'h00;
    dmem_addr = 8'h30; #0.5 hi = dmem_rdata;
    dmem_addr = 8'h31; #0.5 lo = dmem_rdata;
    chk("R3 over-pop return address", {hi, lo}, 16'hFFFF);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = {hi, lo}; rom_data = 8'h77;
    step();
    fetch_valid = 1'b0;
    chk("R2 fetch at 0xFFFF traps", {7'h0, illegal_fetch, opcode}, 16'h0100);
  endtask

  task automatic t_status_write();
    wr_psw(8'hC4);
    chk("R4 write loads all bits", {8'h0, psw_q}, 16'h00C4);
    wr_psw(8'h00);
    chk("R4 write zero", {8'h0, psw_q}, 16'h0000);
  endtask

  task automatic t_events();
    timer_event = 1'b1; step(); timer_event = 1'b0;
    chk("R5 timer sets bit5", {8'h0, psw_q}, 16'h0020);
    ext_rising = 1'b1; ext_pin = 1'b1; step();
    chk("R5 rising edge sets bit3", {8'h0, psw_q}, 16'h0028);
    wr_psw(8'h00);
    ext_pin = 1'b0; step();
    chk("R5 falling ignored when rising selected", {8'h0, psw_q}, 16'h0000);
    ext_rising = 1'b0; step();
    ext_pin = 1'b1; step();
    chk("R5 rising ignored when falling selected", {8'h0, psw_q}, 16'h0000);
    ext_pin = 1'b0; step();
    chk("R5 falling edge sets bit3", {8'h0, psw_q}, 16'h0008);
    ext_rising = 1'b1;
    wr_psw(8'h00);
  endtask

  task automatic t_collision();
    wr_psw(8'h20);
    psw_we = 1'b1; psw_wdata = 8'h00; timer_event = 1'b1;
    step();
    psw_we = 1'b0; timer_event = 1'b0;
    chk("R6 timer event beats clearing write", {8'h0, psw_q}, 16'h0020);
    psw_we = 1'b1; psw_wdata = 8'h00; ext_pin = 1'b1;
    step();
    psw_we = 1'b0;
    chk("R6 ext event beats clearing write", {8'h0, psw_q}, 16'h0008);
    ext_pin = 1'b0; step();
    wr_psw(8'h00);
  endtask

  task automatic t_arbiter();
    wr_psw(8'h3B);
    insn_boundary = 1'b1; sw_trap_req = 1'b1; #0.5;
    chk("R7 ext outranks timer and sw", {13'h0, take}, 16'h0001);
    chk("R7 ext vector", vector, 16'h00F8);
    step();
    chk("R9 hw take clears gie only", {8'h0, psw_q}, 16'h003A);
    insn_boundary = 1'b0; sw_trap_req = 1'b0;
    wr_psw(8'h31);
    insn_boundary = 1'b1; #0.5;
    chk("R7 timer take", {13'h0, take}, 16'h0002);
    chk("R7 timer vector", vector, 16'h00F4);
    sw_trap_req = 1'b1; #0.5;
    chk("R8 sw trap yields to timer", {13'h0, take}, 16'h0002);
    insn_boundary = 1'b0; #0.5;
    chk("R11 no take off boundary", {13'h0, take}, 16'h0000);
    chk("R7 no take vector zero", vector, 16'h0000);
    sw_trap_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_swtrap();
    wr_psw(8'h09);
    insn_boundary = 1'b1; sw_trap_req = 1'b1; #0.5;
    chk("R8 disabled pending does not block sw", {13'h0, take}, 16'h0004);
    chk("R7 sw vector", vector, 16'h00F0);
    step();
    chk("R10 sw take keeps gie", {8'h0, psw_q}, 16'h0009);
    insn_boundary = 1'b0; sw_trap_req = 1'b0;
    wr_psw(8'h3A);
    insn_boundary = 1'b1; sw_trap_req = 1'b1; #0.5;
    chk("R8 gie clear lets sw through", {13'h0, take}, 16'h0004);
    insn_boundary = 1'b0; sw_trap_req = 1'b0;
    @(negedge clk);
    wr_psw(8'h0B);
    insn_boundary = 1'b1; psw_we = 1'b1; psw_wdata = 8'h0B;
    step();
    insn_boundary = 1'b0; psw_we = 1'b0;
    chk("R9 take beats write to gie", {8'h0, psw_q}, 16'h000A);
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; rom_data = '0;
    dmem_addr = '0; dmem_rdata_raw = '0; ext_pin = 1'b0; ext_rising = 1'b1;
    timer_event = 1'b0; psw_we = 1'b0; psw_wdata = '0;
    insn_boundary = 1'b0; sw_trap_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_dmem();
    t_overpop();
    t_status_write();
    t_events();
    t_collision();
    t_arbiter();
    t_swtrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule